// File: doc/BRIEF.md
# Dual-Issue Pairing Check

This block sits after decode in an in-order, two-wide issue stage. In each cycle it is given two decoded instructions in program order: an older one and a younger one. It decides whether the younger instruction may issue in the same cycle as the older one, or must wait for a later slot. Each instruction is described by a valid bit, a 2-bit class, and a double-word flag. It also carries one destination register index with its own valid bit. The younger instruction additionally carries up to three source register indices, each with a valid bit. All register indices address a 64-entry register file.

Only one kind of pair is allowed: a floating-point instruction together with an integer or memory instruction, in either order. The pair is also refused if there is a read-after-write or write-after-write dependency between the two instructions. A double-word memory access covers an even/odd register pair, so its register indices are compared at pair granularity.

The flag `issue_second_o` is combinational. Two registered counters record how many cycles issued a pair and how many issued one instruction alone. These counters are used for checking.

Top module: `dual_issue_pair`

## Requirements
- R1: Class codes are 0 = integer ALU, 1 = load/store, 2 = floating-point, 3 = branch/system. A pair is legal only when one instruction has class 2 and the other has class 0 or 1, in either slot order.
- R2: An instruction of class 3 never pairs, whichever slot it occupies.
- R3: The younger instruction does not pair if any of its three valid source indices matches the older instruction's valid destination (RAW).
- R4: The younger instruction does not pair if both destinations are valid and match (WAW).
- R5: A source or destination whose valid bit is low takes no part in any compare.
- R6: If an instruction has class 1 and its double-word flag is set, each of its indices names the even/odd pair, and bit 0 is ignored when it is compared with the other instruction. The double-word flag has no effect on classes 0, 2 and 3.
- R7: `issue_second_o` is 0 whenever either instruction is invalid.
- R8: `issue_second_o` reflects the current inputs in the same cycle, with no register in the path.
- R9: At each rising clock edge, `pair_cnt_o` increments when a pair is issued. `single_cnt_o` increments when exactly one instruction issues: a valid older instruction that is not paired, or an invalid older instruction with a valid younger one. Neither counter moves when both instructions are invalid. Both counters wrap.
- R10: The asynchronous active-low reset clears both counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| old_vld_i | input | 1 | Older instruction present |
| old_cls_i | input | 2 | Older instruction class |
| old_dbl_i | input | 1 | Older instruction is a double-word access |
| old_dst_vld_i | input | 1 | Older destination valid |
| old_dst_i | input | 6 | Older destination index |
| yng_vld_i | input | 1 | Younger instruction present |
| yng_cls_i | input | 2 | Younger instruction class |
| yng_dbl_i | input | 1 | Younger instruction is a double-word access |
| yng_src_vld_i | input | 3 | Younger source valid bits, bit k for source k |
| yng_src_i | input | 18 | Younger source indices, source k in bits 6k+5:6k |
| yng_dst_vld_i | input | 1 | Younger destination valid |
| yng_dst_i | input | 6 | Younger destination index |
| issue_second_o | output | 1 | Younger instruction issues in this cycle together with the older one |
| pair_cnt_o | output | 16 | Number of paired issues |
| single_cnt_o | output | 16 | Number of single issues |

## Verification
The pairing flag is due in the same cycle as its inputs. The bench applies inputs on the falling edge and samples the flag 1 ns later, before any rising edge occurs. The counters take one register stage. The bench therefore compares them 1 ns after the following rising edge, against running totals that it updates from its own expected flag. Directed scenarios cover every class combination, each source slot, the valid-bit masks, and double-word pair matching. A randomized phase with a small register range then compares the flag against a reference function written from the rules.

// File: rtl/dual_pair_pkg.sv
package dual_pair_pkg;
  typedef enum logic [1:0] {
    CLS_INT = 2'd0,
    CLS_MEM = 2'd1,
    CLS_FPU = 2'd2,
    CLS_SYS = 2'd3
  } ins_cls_e;
endpackage

// File: rtl/pair_class_chk.sv
module pair_class_chk
  import dual_pair_pkg::*;
(
  input  logic [1:0] old_cls_i,
  input  logic [1:0] yng_cls_i,
  output logic       cls_ok_o
);
  ins_cls_e old_cls, yng_cls;
  logic old_fp, yng_fp, old_im, yng_im;

  always_comb begin
    old_cls = ins_cls_e'(old_cls_i);
    yng_cls = ins_cls_e'(yng_cls_i);
    old_fp  = (old_cls == CLS_FPU);
    yng_fp  = (yng_cls == CLS_FPU);
    old_im  = (old_cls == CLS_INT) || (old_cls == CLS_MEM);
    yng_im  = (yng_cls == CLS_INT) || (yng_cls == CLS_MEM);
    cls_ok_o = (old_fp && yng_im) || (yng_fp && old_im);
  end
endmodule

// File: rtl/pair_overlap.sv
module pair_overlap #(
  parameter int REG_W = 6
) (
  input  logic             en_i,
  input  logic             wide_i,
  input  logic [REG_W-1:0] a_i,
  input  logic [REG_W-1:0] b_i,
  output logic             hit_o
);
  logic same_pair, same_reg;

  assign same_pair = (a_i[REG_W-1:1] == b_i[REG_W-1:1]);
  assign same_reg  = same_pair && (a_i[0] == b_i[0]);
  assign hit_o     = en_i && (wide_i ? same_pair : same_reg);
endmodule

// File: rtl/pair_hazard_chk.sv
module pair_hazard_chk #(
  parameter int REG_W   = 6,
  parameter int NUM_SRC = 3,
  localparam int SRC_W  = REG_W * NUM_SRC
) (
  input  logic               old_wide_i,
  input  logic               old_dst_vld_i,
  input  logic [REG_W-1:0]   old_dst_i,
  input  logic               yng_wide_i,
  input  logic [NUM_SRC-1:0] yng_src_vld_i,
  input  logic [SRC_W-1:0]   yng_src_i,
  input  logic               yng_dst_vld_i,
  input  logic [REG_W-1:0]   yng_dst_i,
  output logic               hazard_o
);
  logic               wide;
  logic [NUM_SRC-1:0] raw_hit;
  logic               waw_hit;

  // either side being a register pair widens the compare
  assign wide = old_wide_i || yng_wide_i;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_raw
    pair_overlap #(.REG_W(REG_W)) raw_cmp_i (
      .en_i   (yng_src_vld_i[g] && old_dst_vld_i),
      .wide_i (wide),
      .a_i    (yng_src_i[g*REG_W +: REG_W]),
      .b_i    (old_dst_i),
      .hit_o  (raw_hit[g])
    );
  end

  pair_overlap #(.REG_W(REG_W)) waw_cmp_i (
    .en_i   (yng_dst_vld_i && old_dst_vld_i),
    .wide_i (wide),
    .a_i    (yng_dst_i),
    .b_i    (old_dst_i),
    .hit_o  (waw_hit)
  );

  assign hazard_o = (|raw_hit) || waw_hit;
endmodule

// File: rtl/pair_issue_cnt.sv
module pair_issue_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pair_i,
  input  logic             single_i,
  output logic [CNT_W-1:0] pair_cnt_o,
  output logic [CNT_W-1:0] single_cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pair_cnt_o   <= '0;
      single_cnt_o <= '0;
    end else begin
      if (pair_i)   pair_cnt_o   <= pair_cnt_o + 1'b1;
      if (single_i) single_cnt_o <= single_cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/dual_issue_pair.sv
module dual_issue_pair
  import dual_pair_pkg::*;
#(
  parameter int REG_W   = 6,
  parameter int NUM_SRC = 3,
  parameter int CNT_W   = 16,
  localparam int SRC_W  = REG_W * NUM_SRC
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               old_vld_i,
  input  logic [1:0]         old_cls_i,
  input  logic               old_dbl_i,
  input  logic               old_dst_vld_i,
  input  logic [REG_W-1:0]   old_dst_i,
  input  logic               yng_vld_i,
  input  logic [1:0]         yng_cls_i,
  input  logic               yng_dbl_i,
  input  logic [NUM_SRC-1:0] yng_src_vld_i,
  input  logic [SRC_W-1:0]   yng_src_i,
  input  logic               yng_dst_vld_i,
  input  logic [REG_W-1:0]   yng_dst_i,
  output logic               issue_second_o,
  output logic [CNT_W-1:0]   pair_cnt_o,
  output logic [CNT_W-1:0]   single_cnt_o
);
  logic cls_ok, hazard, old_wide, yng_wide, single_issue;

  // double-word only meaningful for memory class
  assign old_wide = old_dbl_i && (ins_cls_e'(old_cls_i) == CLS_MEM);
  assign yng_wide = yng_dbl_i && (ins_cls_e'(yng_cls_i) == CLS_MEM);

  pair_class_chk cls_i (
    .old_cls_i (old_cls_i),
    .yng_cls_i (yng_cls_i),
    .cls_ok_o  (cls_ok)
  );

  pair_hazard_chk #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) haz_i (
    .old_wide_i    (old_wide),
    .old_dst_vld_i (old_dst_vld_i),
    .old_dst_i     (old_dst_i),
    .yng_wide_i    (yng_wide),
    .yng_src_vld_i (yng_src_vld_i),
    .yng_src_i     (yng_src_i),
    .yng_dst_vld_i (yng_dst_vld_i),
    .yng_dst_i     (yng_dst_i),
    .hazard_o      (hazard)
  );

  assign issue_second_o = old_vld_i && yng_vld_i && cls_ok && !hazard;
  assign single_issue   = (old_vld_i && !issue_second_o) || (!old_vld_i && yng_vld_i);

  pair_issue_cnt #(.CNT_W(CNT_W)) cnt_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pair_i       (issue_second_o),
    .single_i     (single_issue),
    .pair_cnt_o   (pair_cnt_o),
    .single_cnt_o (single_cnt_o)
  );
endmodule

// File: rtl/dual_issue_pair_chk.sv
module dual_issue_pair_chk #(
  parameter int REG_W   = 6,
  parameter int NUM_SRC = 3,
  parameter int CNT_W   = 16,
  localparam int SRC_W  = REG_W * NUM_SRC
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               old_vld_i,
  input logic [1:0]         old_cls_i,
  input logic               old_dst_vld_i,
  input logic [REG_W-1:0]   old_dst_i,
  input logic               yng_vld_i,
  input logic [1:0]         yng_cls_i,
  input logic [NUM_SRC-1:0] yng_src_vld_i,
  input logic [SRC_W-1:0]   yng_src_i,
  input logic               yng_dst_vld_i,
  input logic [REG_W-1:0]   yng_dst_i,
  input logic               issue_second_o,
  input logic [CNT_W-1:0]   pair_cnt_o,
  input logic [CNT_W-1:0]   single_cnt_o
);
  // R1
  pair_class_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_second_o |-> ((old_cls_i == 2'd2 && yng_cls_i[1] == 1'b0) ||
                        (yng_cls_i == 2'd2 && old_cls_i[1] == 1'b0)));

  // R7
  pair_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_second_o |-> (old_vld_i && yng_vld_i));

  // R4
  no_waw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_second_o |-> !(old_dst_vld_i && yng_dst_vld_i && old_dst_i == yng_dst_i));

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_raw
    // R3
    no_raw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      issue_second_o |-> !(old_dst_vld_i && yng_src_vld_i[g] &&
                           yng_src_i[g*REG_W +: REG_W] == old_dst_i));
  end

  // R9
  pair_cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_second_o |=> (pair_cnt_o == $past(pair_cnt_o) + 1'b1));

  // R9
  idle_no_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!old_vld_i && !yng_vld_i) |=> ($stable(pair_cnt_o) && $stable(single_cnt_o)));
endmodule

bind dual_issue_pair dual_issue_pair_chk #(
  .REG_W(REG_W), .NUM_SRC(NUM_SRC), .CNT_W(CNT_W)
) chk_i (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .old_vld_i      (old_vld_i),
  .old_cls_i      (old_cls_i),
  .old_dst_vld_i  (old_dst_vld_i),
  .old_dst_i      (old_dst_i),
  .yng_vld_i      (yng_vld_i),
  .yng_cls_i      (yng_cls_i),
  .yng_src_vld_i  (yng_src_vld_i),
  .yng_src_i      (yng_src_i),
  .yng_dst_vld_i  (yng_dst_vld_i),
  .yng_dst_i      (yng_dst_i),
  .issue_second_o (issue_second_o),
  .pair_cnt_o     (pair_cnt_o),
  .single_cnt_o   (single_cnt_o)
);

// File: tb/dual_issue_pair_tb_top.sv
`timescale 1ns/1ps
module dual_issue_pair_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        old_vld, old_dbl, old_dv, yng_vld, yng_dbl, yng_dv;
  logic [1:0]  old_cls, yng_cls;
  logic [5:0]  old_dst, yng_dst;
  logic [2:0]  yng_sv;
  logic [17:0] yng_src;
  logic        issue2;
  logic [15:0] pair_cnt, single_cnt;

  int unsigned n_chk = 0, n_fail = 0;
  int unsigned exp_pair = 0, exp_single = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dual_issue_pair dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .old_vld_i(old_vld), .old_cls_i(old_cls), .old_dbl_i(old_dbl),
    .old_dst_vld_i(old_dv), .old_dst_i(old_dst),
    .yng_vld_i(yng_vld), .yng_cls_i(yng_cls), .yng_dbl_i(yng_dbl),
    .yng_src_vld_i(yng_sv), .yng_src_i(yng_src),
    .yng_dst_vld_i(yng_dv), .yng_dst_i(yng_dst),
    .issue_second_o(issue2), .pair_cnt_o(pair_cnt), .single_cnt_o(single_cnt)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clr();
    old_vld = 0; old_cls = 0; old_dbl = 0; old_dv = 0; old_dst = 0;
    yng_vld = 0; yng_cls = 0; yng_dbl = 0; yng_sv = 0; yng_src = 0;
    yng_dv = 0; yng_dst = 0;
  endtask

  task automatic set_pair(input logic [1:0] oc, input logic [1:0] yc);
    clr(); old_vld = 1; yng_vld = 1; old_cls = oc; yng_cls = yc;
  endtask

  function automatic bit same(input logic [5:0] a, input logic [5:0] b, input bit w);
    return w ? (a[5:1] == b[5:1]) : (a == b);
  endfunction

  function automatic bit ref_issue();
    bit ok, w, hz;
    ok = (old_cls == 2 && yng_cls < 2) || (yng_cls == 2 && old_cls < 2);
    w  = (old_dbl && old_cls == 1) || (yng_dbl && yng_cls == 1);
    hz = 0;
    for (int k = 0; k < 3; k++)
      if (yng_sv[k] && old_dv && same(yng_src[k*6 +: 6], old_dst, w)) hz = 1;
    if (yng_dv && old_dv && same(yng_dst, old_dst, w)) hz = 1;
    return old_vld && yng_vld && ok && !hz;
  endfunction

  // inputs set just after a falling edge; flag sampled now, counters after next rise
  task automatic step(input bit exp, input string req);
    #1;
    check({req, " R8 issue_second"}, int'(issue2), int'(exp));
    if (exp) exp_pair++;
    else if (old_vld || yng_vld) exp_single++;
    @(posedge clk); #1;
    check("R9 pair_cnt", int'(pair_cnt), int'(exp_pair & 16'hffff));
    check("R9 single_cnt", int'(single_cnt), int'(exp_single & 16'hffff));
    @(negedge clk);
  endtask

  task automatic t_reset();
    clr();
    #1;
    check("R10 pair_cnt reset", int'(pair_cnt), 0);
    check("R10 single_cnt reset", int'(single_cnt), 0);
    check("R7 idle issue", int'(issue2), 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    step(0, "R9 idle");
  endtask

  task automatic t_class();
    for (int o = 0; o < 4; o++)
      for (int y = 0; y < 4; y++) begin
        bit e;
        e = (o == 2 && y < 2) || (y == 2 && o < 2);
        set_pair(2'(o), 2'(y));
        step(e, (o == 3 || y == 3) ? "R2" : "R1");
      end
  endtask

  task automatic t_raw();
    for (int k = 0; k < 3; k++) begin
      set_pair(2, 0); old_dv = 1; old_dst = 10;
      yng_sv[k] = 1; yng_src[k*6 +: 6] = 10;
      step(0, "R3 raw");
      yng_sv[k] = 0;
      step(1, "R5 src invalid");
    end
    set_pair(0, 2); old_dv = 1; old_dst = 33; yng_sv = 3'b111;
    yng_src = {6'd32, 6'd34, 6'd1};
    step(1, "R3 no match");
  endtask

  task automatic t_waw();
    set_pair(1, 2); old_dv = 1; old_dst = 20; yng_dv = 1; yng_dst = 20;
    step(0, "R4 waw");
    yng_dv = 0;
    step(1, "R5 dst invalid");
    yng_dv = 1; old_dv = 0;
    step(1, "R5 old dst invalid");
  endtask

  task automatic t_dbl();
    set_pair(1, 2); old_dbl = 1; old_dv = 1; old_dst = 8; yng_sv = 3'b001; yng_src[5:0] = 9;
    step(0, "R6 dbl old");
    old_dbl = 0;
    step(1, "R6 narrow");
    set_pair(2, 0); old_dbl = 1; old_dv = 1; old_dst = 8; yng_sv = 3'b010; yng_src[11:6] = 9;
    step(1, "R6 dbl ignored fpu");
    set_pair(2, 1); yng_dbl = 1; old_dv = 1; old_dst = 12; yng_dv = 1; yng_dst = 13;
    step(0, "R6 dbl yng waw");
  endtask

  task automatic t_invalid();
    set_pair(2, 0); old_vld = 0;
    step(0, "R7 old invalid");
    set_pair(2, 0); yng_vld = 0;
    step(0, "R7 yng invalid");
    clr();
    step(0, "R9 both invalid");
  endtask

  task automatic t_random();
    for (int i = 0; i < 400; i++) begin
      old_vld = ($urandom_range(9) != 0); yng_vld = ($urandom_range(9) != 0);
      old_cls = 2'($urandom); yng_cls = 2'($urandom);
      old_dbl = 1'($urandom); yng_dbl = 1'($urandom);
      old_dv = 1'($urandom); yng_dv = 1'($urandom);
      old_dst = 6'($urandom_range(7)); yng_dst = 6'($urandom_range(7));
      yng_sv = 3'($urandom);
      for (int k = 0; k < 3; k++) yng_src[k*6 +: 6] = 6'($urandom_range(7));
      step(ref_issue(), "R1 R3 R4 R6 random");
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    clr();
    @(negedge clk);
    t_reset();
    t_class();
    t_raw();
    t_waw();
    t_dbl();
    t_invalid();
    t_random();
    finish_run();
  end
endmodule